// File: doc/BRIEF.md
# Instruction Trace Counter Unit

This unit counts the instructions a processor core retires and raises a trace flag for an on-chip debug controller once a programmed number of them have run. Software loads a count and then writes a control word that selects a trace mode and an action. Each instruction the core completes outside debug mode lowers the count by one. The flag rises the first time the count is zero while trace is enabled. No further qualifying event is needed.

The action field picks what follows the flag. One choice requests debug entry after one more instruction. Another freezes the instruction capture FIFO. The other two pull a shared active-low event line. Once set, the flag is sticky. While trace stays enabled, a rewrite of the control word cannot clear it. Only a control write that turns trace off clears it. Software then reloads the count and enables trace again. A load of zero followed by enabling trace with the debug-entry action single-steps the core.

Top module: `instr_trace_unit`

## Requirements
- R1: After synchronous reset the flag, FIFO-halt request, debug-entry request and sequential-hit flag are 0 and `dbg_event_n` is 1. The latched mode is 5'b00000, the latched action is 2'b00 and the counter is 0.
- R2: A `ctrl_wr` pulse latches `mode_sel` and `action`. Trace is enabled while the latched mode is 5'b10111 or any code of the form 5'b110xx.
- R3: While trace is enabled, each `insn_exec` pulse with `in_debug` low lowers the counter by one. The counter holds at zero. While trace is disabled, strobes leave the counter unchanged.
- R4: `insn_exec` pulses with `in_debug` high never lower the counter.
- R5: A `cnt_wr` pulse loads `cnt_wdata`. It wins over a decrement strobe in the same cycle.
- R6: The flag sets on the clock edge after the counter is zero with trace enabled. A load of n followed by enabling trace sets the flag one cycle after the n-th counted instruction.
- R7: With action 2'b00, `debug_req` rises on the edge of the first normal-mode `insn_exec` pulse that arrives while the flag is already set. Strobes in debug mode do not count.
- R8: With action 2'b01, `fifo_halt` is high exactly while the flag is set. In that case `dbg_event_n` stays 1 and `debug_req` stays 0.
- R9: With action 2'b10 or 2'b11, `dbg_event_n` is low exactly while the flag is set. No FIFO halt or debug-entry request is made.
- R10: A control write that keeps trace enabled does not clear a set flag. A control write with a non-trace mode clears the flag, `debug_req` and `seqbp_hit` on its own edge.
- R11: The 5'b110xx modes count and flag exactly like 5'b10111. They also set `seqbp_hit` together with the flag.
- R12: A zero count, then enabling trace with action 2'b00, sets the flag one cycle later. One normal instruction after that raises `debug_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 5 | Mode code latched by a control write |
| action | input | 2 | Event action latched by a control write |
| ctrl_wr | input | 1 | Control register write strobe |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter load value |
| insn_exec | input | 1 | One-cycle pulse per instruction executed by the core |
| in_debug | input | 1 | Core is in debug mode |
| trace_flag | output | 1 | Trace-occurred flag |
| dbg_event_n | output | 1 | Active-low debug event line |
| fifo_halt | output | 1 | Capture FIFO halt request |
| debug_req | output | 1 | Debug-mode entry request |
| seqbp_hit | output | 1 | Sequential-breakpoint hit flag |

## Verification
The counting path is tried with loads of 1, 2 and 3. It is also tried with instruction strobes sent while trace is off, strobes flagged as debug-mode, and a load that collides with a strobe. Each pattern would show a miscount as a flag rising one cycle early or late. Every action code is tried on its own, so a swapped output decode shows up as the wrong line moving. The rearm pattern rewrites an enabled mode while the flag is set and then runs the disable–reload–enable sequence. That separates a sticky flag from one cleared by any control write. A sequential mode and a zero-count single step complete the set.

// File: rtl/itrace_pkg.sv
package itrace_pkg;

    localparam int MODE_W = 5;
    localparam int ACT_W  = 2;

    localparam logic [MODE_W-1:0] MODE_TRACE    = 5'b10111;
    localparam logic [2:0]        SEQ_TRACE_TOP = 3'b110;

    typedef enum logic [ACT_W-1:0] {
        ACT_DEBUG = 2'b00,
        ACT_FIFO  = 2'b01,
        ACT_EVT_A = 2'b10,
        ACT_EVT_B = 2'b11
    } act_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        act_e              act;
    } ctrl_t;

    typedef struct packed {
        logic flag;
        logic fifo_halt;
        logic dbg_event_n;
        logic debug_req;
        logic seqbp;
    } evt_t;

    function automatic logic is_seq_trace(input logic [MODE_W-1:0] m);
        return m[MODE_W-1 -: 3] == SEQ_TRACE_TOP;
    endfunction

    function automatic logic is_trace(input logic [MODE_W-1:0] m);
        return (m == MODE_TRACE) || is_seq_trace(m);
    endfunction

endpackage

// File: rtl/itrace_ctrl.sv
module itrace_ctrl
    import itrace_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [ACT_W-1:0]  action,
    output ctrl_t             ctrl_q,
    output logic              trace_en,
    output logic              seq_en,
    output logic              disarm
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mode <= '0;
            ctrl_q.act  <= ACT_DEBUG;
        end else if (ctrl_wr) begin
            ctrl_q.mode <= mode_sel;
            ctrl_q.act  <= act_e'(action);
        end
    end

    always_comb begin
        trace_en = is_trace(ctrl_q.mode);
        seq_en   = is_seq_trace(ctrl_q.mode);
        disarm   = ctrl_wr && !is_trace(mode_sel);
    end

    // R2: a control write lands in the latched word on the next edge
    assert_ctrl_latch_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (ctrl_q.mode == $past(mode_sel)));

endmodule

// File: rtl/itrace_counter.sv
module itrace_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trace_en,
    input  logic             insn_exec,
    input  logic             in_debug,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic             cnt_zero,
    output logic             normal_insn
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             dec_en;

    always_comb begin
        normal_insn = insn_exec && !in_debug;
        cnt_zero    = (cnt_q == '0);
        dec_en      = trace_en && normal_insn && !cnt_zero;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= cnt_wdata;
        else if (dec_en)
            cnt_q <= cnt_q - ONE;
    end

    // R3: the counter saturates at zero
    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cnt_zero && !cnt_wr) |=> cnt_zero);

    // R4: debug-mode strobes leave the count alone
    assert_debug_no_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (in_debug && !cnt_wr) |=> $stable(cnt_q));

    // R5: a load wins over a concurrent decrement
    assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));

endmodule

// File: rtl/itrace_event.sv
module itrace_event
    import itrace_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  trace_en,
    input  logic  seq_en,
    input  act_e  act,
    input  logic  cnt_zero,
    input  logic  disarm,
    input  logic  normal_insn,
    output evt_t  evt
);

    logic flag_q, seq_q, dreq_q;

    always_ff @(posedge clk) begin
        if (rst || disarm) begin
            flag_q <= 1'b0;
            seq_q  <= 1'b0;
            dreq_q <= 1'b0;
        end else begin
            if (trace_en && cnt_zero) begin
                flag_q <= 1'b1;
                if (seq_en) seq_q <= 1'b1;
            end
            if (flag_q && act == ACT_DEBUG && normal_insn)
                dreq_q <= 1'b1;
        end
    end

    always_comb begin
        evt.flag        = flag_q;
        evt.seqbp       = seq_q;
        evt.debug_req   = dreq_q;
        evt.fifo_halt   = flag_q && (act == ACT_FIFO);
        evt.dbg_event_n = !(flag_q && act[1]);
    end

    // R10: only a disabling control write can clear the flag
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !disarm) |=> flag_q);

    // R10: a disabling write clears every event output
    assert_disarm_clears_R10: assert property (@(posedge clk) disable iff (rst)
        disarm |=> (!flag_q && !dreq_q && !seq_q));

    // R7: debug entry follows a flag that was already set
    assert_dreq_after_flag_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dreq_q) |-> $past(flag_q));

    // R11: the sequential hit never stands without the flag
    assert_seq_with_flag_R11: assert property (@(posedge clk) disable iff (rst)
        seq_q |-> flag_q);

endmodule

// File: rtl/instr_trace_unit.sv
module instr_trace_unit
    import itrace_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       mode_sel,
    input  logic [1:0]       action,
    input  logic             ctrl_wr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             insn_exec,
    input  logic             in_debug,
    output logic             trace_flag,
    output logic             dbg_event_n,
    output logic             fifo_halt,
    output logic             debug_req,
    output logic             seqbp_hit
);

    ctrl_t ctrl_q;
    evt_t  evt;
    logic  trace_en, seq_en, disarm, cnt_zero, normal_insn;

    itrace_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .mode_sel (mode_sel),
        .action   (action),
        .ctrl_q   (ctrl_q),
        .trace_en (trace_en),
        .seq_en   (seq_en),
        .disarm   (disarm)
    );

    itrace_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .trace_en    (trace_en),
        .insn_exec   (insn_exec),
        .in_debug    (in_debug),
        .cnt_wr      (cnt_wr),
        .cnt_wdata   (cnt_wdata),
        .cnt_zero    (cnt_zero),
        .normal_insn (normal_insn)
    );

    itrace_event u_evt (
        .clk         (clk),
        .rst         (rst),
        .trace_en    (trace_en),
        .seq_en      (seq_en),
        .act         (ctrl_q.act),
        .cnt_zero    (cnt_zero),
        .disarm      (disarm),
        .normal_insn (normal_insn),
        .evt         (evt)
    );

    assign trace_flag  = evt.flag;
    assign dbg_event_n = evt.dbg_event_n;
    assign fifo_halt   = evt.fifo_halt;
    assign debug_req   = evt.debug_req;
    assign seqbp_hit   = evt.seqbp;

    // R9: the event line only drops while the flag is up
    assert_evt_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
        !dbg_event_n |-> trace_flag);

    // R8: a FIFO halt request only stands with the flag
    assert_halt_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_halt |-> trace_flag);

endmodule

// File: tb/sim_instr_trace_unit.sv
module sim_instr_trace_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] mode_sel = '0;
    logic [1:0] action = '0;
    logic       ctrl_wr = 1'b0, cnt_wr = 1'b0, insn_exec = 1'b0, in_debug = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic       trace_flag, dbg_event_n, fifo_halt, debug_req, seqbp_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    instr_trace_unit u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .action(action),
        .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .insn_exec(insn_exec), .in_debug(in_debug),
        .trace_flag(trace_flag), .dbg_event_n(dbg_event_n),
        .fifo_halt(fifo_halt), .debug_req(debug_req), .seqbp_hit(seqbp_hit)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [4:0] m, input logic [1:0] a);
        mode_sel = m; action = a; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wdata = v; cnt_wr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic insn(input logic dbg);
        insn_exec = 1'b1; in_debug = dbg;
        @(negedge clk);
        insn_exec = 1'b0; in_debug = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        idle();
        chk("R1 flag", trace_flag, 1'b0);
        chk("R1 dbg_event_n", dbg_event_n, 1'b1);
        chk("R1 fifo_halt", fifo_halt, 1'b0);
        chk("R1 debug_req", debug_req, 1'b0);
        chk("R1 seqbp", seqbp_hit, 1'b0);
    endtask

    task automatic t_count_three();
        do_reset();
        wr_cnt(8'd3);
        wr_ctrl(5'b10111, 2'b11);
        insn(1'b0); insn(1'b0); idle();
        chk("R6 flag low after two of three", trace_flag, 1'b0);
        insn(1'b0);
        chk("R6 flag not yet on zero edge", trace_flag, 1'b0);
        idle();
        chk("R6 flag after third", trace_flag, 1'b1);
        chk("R9 event low act 11", dbg_event_n, 1'b0);
        chk("R9 no halt act 11", fifo_halt, 1'b0);
        chk("R11 no seqbp plain mode", seqbp_hit, 1'b0);
    endtask

    task automatic t_act10();
        do_reset();
        wr_cnt(8'd2);
        wr_ctrl(5'b10111, 2'b10);
        insn(1'b0); idle();
        chk("R9 event high before flag", dbg_event_n, 1'b1);
        insn(1'b0); idle();
        chk("R9 event low act 10", dbg_event_n, 1'b0);
        insn(1'b0); idle();
        chk("R9 no debug_req act 10", debug_req, 1'b0);
    endtask

    task automatic t_no_trace_count();
        do_reset();
        wr_cnt(8'd2);
        insn(1'b0); insn(1'b0); insn(1'b0);
        wr_ctrl(5'b10111, 2'b11); idle();
        chk("R3 no count while disabled", trace_flag, 1'b0);
        insn(1'b0); idle();
        chk("R3 one of two", trace_flag, 1'b0);
        insn(1'b0); idle();
        chk("R3 flag after two", trace_flag, 1'b1);
    endtask

    task automatic t_debug_insns();
        do_reset();
        wr_cnt(8'd1);
        wr_ctrl(5'b10111, 2'b11);
        insn(1'b1); insn(1'b1); insn(1'b1); idle();
        chk("R4 debug strobes ignored", trace_flag, 1'b0);
        insn(1'b0); idle();
        chk("R4 normal strobe counts", trace_flag, 1'b1);
    endtask

    task automatic t_priority();
        do_reset();
        wr_ctrl(5'b10111, 2'b11);
        idle();
        chk("R6 zero count flags at once", trace_flag, 1'b1);
        wr_ctrl(5'b00000, 2'b11);
        wr_cnt(8'd1);
        wr_ctrl(5'b10111, 2'b11);
        cnt_wdata = 8'd2; cnt_wr = 1'b1; insn_exec = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0; insn_exec = 1'b0;
        insn(1'b0); idle();
        chk("R5 load beat strobe", trace_flag, 1'b0);
        insn(1'b0); idle();
        chk("R5 flag after loaded two", trace_flag, 1'b1);
    endtask

    task automatic t_single_step();
        do_reset();
        wr_ctrl(5'b10111, 2'b00);
        chk("R12 flag not on enable edge", trace_flag, 1'b0);
        idle();
        chk("R12 flag one cycle later", trace_flag, 1'b1);
        chk("R12 no request yet", debug_req, 1'b0);
        chk("R9 event high act 00", dbg_event_n, 1'b1);
        insn(1'b1);
        chk("R7 debug strobe no request", debug_req, 1'b0);
        insn(1'b0);
        chk("R7 request after extra insn", debug_req, 1'b1);
        chk("R12 request raised", debug_req, 1'b1);
    endtask

    task automatic t_fifo_halt();
        do_reset();
        wr_cnt(8'd1);
        wr_ctrl(5'b10111, 2'b01);
        idle();
        chk("R8 no halt before flag", fifo_halt, 1'b0);
        insn(1'b0); idle();
        chk("R8 halt with flag", fifo_halt, 1'b1);
        chk("R8 event high", dbg_event_n, 1'b1);
        insn(1'b0);
        chk("R8 no debug_req", debug_req, 1'b0);
        wr_ctrl(5'b00000, 2'b01);
        chk("R8 halt drops with flag", fifo_halt, 1'b0);
    endtask

    task automatic t_sticky();
        do_reset();
        wr_cnt(8'd1);
        wr_ctrl(5'b10111, 2'b11);
        insn(1'b0); idle();
        chk("R10 flag set", trace_flag, 1'b1);
        wr_ctrl(5'b10111, 2'b11); idle();
        chk("R10 rearm write no effect", trace_flag, 1'b1);
        chk("R10 event still low", dbg_event_n, 1'b0);
        wr_ctrl(5'b00000, 2'b11);
        chk("R10 disable clears flag", trace_flag, 1'b0);
        chk("R10 disable raises event", dbg_event_n, 1'b1);
        wr_cnt(8'd2);
        wr_ctrl(5'b10111, 2'b11);
        insn(1'b0); idle();
        chk("R10 rearmed not early", trace_flag, 1'b0);
        insn(1'b0); idle();
        chk("R10 rearmed flag sets", trace_flag, 1'b1);
    endtask

    task automatic t_seq();
        do_reset();
        wr_cnt(8'd1);
        wr_ctrl(5'b11010, 2'b11);
        idle();
        chk("R11 seqbp low before flag", seqbp_hit, 1'b0);
        insn(1'b0); idle();
        chk("R11 seq mode flags", trace_flag, 1'b1);
        chk("R11 seqbp set", seqbp_hit, 1'b1);
        chk("R2 seq code enables trace", dbg_event_n, 1'b0);
        wr_ctrl(5'b00000, 2'b11);
        chk("R10 seqbp cleared", seqbp_hit, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_count_three();
        t_act10();
        t_no_trace_count();
        t_debug_insns();
        t_priority();
        t_single_step();
        t_fifo_halt();
        t_sticky();
        t_seq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule